// File: doc/BRIEF.md
# Coincident-Selection Static RAM Array

A small bit-organized static RAM whose cells sit in a square two-dimensional grid. A row decoder and a column decoder each drive one set of select lines. A cell is chosen only where an active row line crosses an active column line, so no single wide linear decoder is needed. The upper address bits feed the row decoder and the lower bits feed the column decoder. Chip select enables only the column decoder, so when the chip is deselected no column is active and no cell can be reached.

The same grid can hold words wider than one bit. Each column-decoder output then selects a group of `DATA_W` adjacent columns. With the default 4x4 grid, `DATA_W = 1` gives a 16x1 memory and `DATA_W = 2` gives an 8x2 memory. A read collects the selected cells through an OR network and sends them to a tri-state output. The output is driven only during a chip-selected read. A write stores the input word into the selected cells on the rising clock edge.

Top module: `coinc_sram`

## Requirements
- R1: `addr_i` is split into two fields. The top `ROWS_LG` bits pick exactly one of the 2^ROWS_LG rows. The remaining low bits pick a column group.
- R2: An access reaches only the cells where the active row crosses the active columns. In the 16x1 layout, address 9 (row 2, column 1) holds its own bit, and writing it leaves addresses 8, 10, 1 and 13 unchanged.
- R3: With `cs_i` = 0 every column select is 0. A write attempted in that state leaves the array unchanged, and `oe_o` is 0.
- R4: With `cs_i` = 1 and `we_i` = 1, `data_i` is stored on the rising edge of `clk_i`. A read returns the stored word combinationally from `addr_i`.
- R5: A read leaves the stored contents unchanged. Reading the same address again returns the same word.
- R6: When `DATA_W` > 1, column group g covers columns g*DATA_W to g*DATA_W+DATA_W-1, and data bit j maps to column g*DATA_W+j. In the 8x2 layout, address 3 selects row 1 and columns 2 and 3 (cells 6 and 7), and each address holds an independent 2-bit word.
- R7: `oe_o` is 1 exactly when `cs_i` = 1 and `we_i` = 0. `data_o` carries the read word only then, and is high impedance otherwise.
- R8: An active-low `rst_ni` clears every cell to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes occur on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the array |
| addr_i | input | ROWS_LG+COLS_LG-$clog2(DATA_W) | Row field in the upper bits, column group in the lower bits |
| cs_i | input | 1 | Chip select; gates the column decoder |
| we_i | input | 1 | 1 = write, 0 = read |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, high impedance when not enabled |
| oe_o | output | 1 | High while `data_o` is driven |

## Verification
The bench builds two copies on the default 4x4 grid: one with `DATA_W = 1` (16x1) and one with `DATA_W = 2` (8x2). The 16x1 copy exercises the single-cell crossing around address 9, writes ignored under deselect, and full-array patterns read twice. The 8x2 copy shows that column groups of two adjacent columns form independent 2-bit words with correct bit order, including the word at address 3.

// File: rtl/coinc_sram_pkg.sv
package coinc_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  function automatic sram_op_e decode_op(logic cs, logic we);
    if (!cs)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction
endpackage

// File: rtl/coinc_row_dec.sv
module coinc_row_dec #(
  parameter int ROWS_LG = 2,
  localparam int ROWS = 1 << ROWS_LG
) (
  input  logic [ROWS_LG-1:0] row_i,
  output logic [ROWS-1:0]    row_sel_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel_o[r] = (row_i == ROWS_LG'(r));
  end
endmodule

// File: rtl/coinc_col_dec.sv
module coinc_col_dec #(
  parameter int COLS_LG = 2,
  parameter int DATA_W  = 1,
  localparam int COLS    = 1 << COLS_LG,
  localparam int CSEL_LG = COLS_LG - $clog2(DATA_W)
) (
  input  logic               en_i,
  input  logic [CSEL_LG-1:0] grp_i,
  output logic [COLS-1:0]    col_sel_o
);
  // each decoder output fans out to DATA_W adjacent columns
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel_o[c] = en_i && (grp_i == CSEL_LG'(c / DATA_W));
  end
endmodule

// File: rtl/coinc_cell_array.sv
module coinc_cell_array #(
  parameter int ROWS_LG = 2,
  parameter int COLS_LG = 2,
  parameter int DATA_W  = 1,
  localparam int ROWS = 1 << ROWS_LG,
  localparam int COLS = 1 << COLS_LG,
  localparam int GRPS = COLS / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROWS-1:0]   row_sel_i,
  input  logic [COLS-1:0]   col_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ROWS-1:0][COLS-1:0] cells_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cells_q[r][c] <= 1'b0;
        else if (wr_en_i && row_sel_i[r] && col_sel_i[c])
          cells_q[r][c] <= wdata_i[c % DATA_W];
      end
    end
  end

  // OR-gather of every selected cell onto its data bit
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < ROWS; r++)
      for (int g = 0; g < GRPS; g++)
        for (int j = 0; j < DATA_W; j++)
          rdata_o[j] = rdata_o[j] |
            (row_sel_i[r] & col_sel_i[g*DATA_W+j] & cells_q[r][g*DATA_W+j]);
  end
endmodule

// File: rtl/coinc_sram.sv
module coinc_sram
  import coinc_sram_pkg::*;
#(
  parameter int ROWS_LG = 2,
  parameter int COLS_LG = 2,
  parameter int DATA_W  = 1,
  localparam int ROWS    = 1 << ROWS_LG,
  localparam int COLS    = 1 << COLS_LG,
  localparam int CSEL_LG = COLS_LG - $clog2(DATA_W),
  localparam int ADDR_W  = ROWS_LG + CSEL_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  sram_op_e          op;
  logic [ROWS-1:0]   row_sel;
  logic [COLS-1:0]   col_sel;
  logic [DATA_W-1:0] rd_data;

  assign op = decode_op(cs_i, we_i);

  coinc_row_dec #(.ROWS_LG(ROWS_LG)) i_row_dec (
    .row_i     (addr_i[ADDR_W-1:CSEL_LG]),
    .row_sel_o (row_sel)
  );

  coinc_col_dec #(.COLS_LG(COLS_LG), .DATA_W(DATA_W)) i_col_dec (
    .en_i      (cs_i),
    .grp_i     (addr_i[CSEL_LG-1:0]),
    .col_sel_o (col_sel)
  );

  coinc_cell_array #(.ROWS_LG(ROWS_LG), .COLS_LG(COLS_LG), .DATA_W(DATA_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_sel_i (row_sel),
    .col_sel_i (col_sel),
    .wr_en_i   (op == OP_WRITE),
    .wdata_i   (data_i),
    .rdata_o   (rd_data)
  );

  assign oe_o   = (op == OP_READ);
  assign data_o = oe_o ? rd_data : 'z;
endmodule

// File: rtl/coinc_sram_chk.sv
module coinc_sram_chk #(
  parameter int ROWS_LG = 2,
  parameter int COLS_LG = 2,
  parameter int DATA_W  = 1,
  parameter int ADDR_W  = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        addr_i,
  input logic                     cs_i,
  input logic                     we_i,
  input logic [DATA_W-1:0]        data_i,
  input logic                     oe_o,
  input logic [(1<<ROWS_LG)-1:0]  row_sel,
  input logic [(1<<COLS_LG)-1:0]  col_sel,
  input logic [DATA_W-1:0]        rd_data
);
  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_sel) == 1); // R1

  AST_COL_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |-> $countones(col_sel) == DATA_W); // R2

  AST_CS_GATES_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> col_sel == '0); // R3

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cs_i && we_i) && cs_i && !we_i && addr_i == $past(addr_i))
      |-> rd_data == $past(data_i)); // R4

  AST_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_i && !we_i) && cs_i && !we_i && $stable(addr_i))
      |-> $stable(rd_data)); // R5

  AST_OE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (cs_i && !we_i)); // R7
endmodule

bind coinc_sram coinc_sram_chk #(
  .ROWS_LG(ROWS_LG), .COLS_LG(COLS_LG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .cs_i    (cs_i),
  .we_i    (we_i),
  .data_i  (data_i),
  .oe_o    (oe_o),
  .row_sel (row_sel),
  .col_sel (col_sel),
  .rd_data (rd_data)
);

// File: tb/test_coinc_sram.sv
module test_coinc_sram;
  typedef struct {
    logic       oe;
    logic [1:0] data;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   fails = 0;
  always #4 clk = ~clk;

  // 16x1 copy
  logic [3:0] addr_a = '0;
  logic       cs_a = 1'b0, we_a = 1'b0;
  logic [0:0] din_a = '0;
  logic [0:0] dout_a;
  logic       oe_a;
  logic       ref_a [16];
  exp_t       q_a [$];

  // 8x2 copy
  logic [2:0] addr_b = '0;
  logic       cs_b = 1'b0, we_b = 1'b0;
  logic [1:0] din_b = '0;
  logic [1:0] dout_b;
  logic       oe_b;
  logic [1:0] ref_b [8];
  exp_t       q_b [$];

  coinc_sram #(.ROWS_LG(2), .COLS_LG(2), .DATA_W(1)) i_coinc_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_a), .cs_i(cs_a), .we_i(we_a),
    .data_i(din_a), .data_o(dout_a), .oe_o(oe_a)
  );

  coinc_sram #(.ROWS_LG(2), .COLS_LG(2), .DATA_W(2)) i_coinc_sram_w2 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_b), .cs_i(cs_b), .we_i(we_b),
    .data_i(din_b), .data_o(dout_b), .oe_o(oe_b)
  );

  task automatic wr_a(int a, logic d, logic cs, string req);
    @(negedge clk);
    addr_a = 4'(a); cs_a = cs; we_a = 1'b1; din_a = d;
    if (cs) ref_a[a] = d;
    q_a.push_back('{oe: 1'b0, data: 2'b00, req: req});
  endtask

  task automatic rd_a(int a, string req);
    @(negedge clk);
    addr_a = 4'(a); cs_a = 1'b1; we_a = 1'b0;
    q_a.push_back('{oe: 1'b1, data: {1'b0, ref_a[a]}, req: req});
  endtask

  task automatic idle_a(int a, string req);
    @(negedge clk);
    addr_a = 4'(a); cs_a = 1'b0; we_a = 1'b0;
    q_a.push_back('{oe: 1'b0, data: 2'b00, req: req});
  endtask

  task automatic wr_b(int a, logic [1:0] d, string req);
    @(negedge clk);
    addr_b = 3'(a); cs_b = 1'b1; we_b = 1'b1; din_b = d;
    ref_b[a] = d;
    q_b.push_back('{oe: 1'b0, data: 2'b00, req: req});
  endtask

  task automatic rd_b(int a, string req);
    @(negedge clk);
    addr_b = 3'(a); cs_b = 1'b1; we_b = 1'b0;
    q_b.push_back('{oe: 1'b1, data: ref_b[a], req: req});
  endtask

  task automatic compare(string tag, exp_t it, logic oe, logic [1:0] d);
    checks++;
    if (oe !== it.oe) begin
      fails++;
      $display("FAIL %s %s oe_o actual=%b expected=%b", tag, it.req, oe, it.oe);
    end else if (it.oe && d !== it.data) begin
      fails++;
      $display("FAIL %s %s data_o actual=%b expected=%b", tag, it.req, d, it.data);
    end
  endtask

  // monitors: sample one time unit after the edge that follows each drive
  initial forever begin
    @(posedge clk); #1;
    if (q_a.size() > 0) compare("16x1", q_a.pop_front(), oe_a, {1'b0, dout_a});
  end

  initial forever begin
    @(posedge clk); #1;
    if (q_b.size() > 0) compare("8x2", q_b.pop_front(), oe_b, dout_b);
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_a[i] = 1'b0;
    for (int i = 0; i < 8; i++) ref_b[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    for (int i = 0; i < 16; i++) rd_a(i, "R8 reset clear");
    for (int i = 0; i < 8; i++) rd_b(i, "R8 reset clear");

    // R2 / R4: single crossing at address 9
    wr_a(9, 1'b1, 1'b1, "R4 write, R7 no drive");
    rd_a(9, "R4 readback");
    rd_a(8, "R2 same row");
    rd_a(10, "R2 same row");
    rd_a(1, "R2 same column");
    rd_a(13, "R2 same column");

    // R3: deselected write ignored, output idle
    wr_a(5, 1'b1, 1'b0, "R3 write deselected");
    idle_a(5, "R3 R7 deselected read");
    rd_a(5, "R3 cell unchanged");

    // R1 / R5: full pattern, read twice
    for (int i = 0; i < 16; i++) wr_a(i, 1'((i ^ (i >> 2)) & 1), 1'b1, "R7 no drive");
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 16; i++) rd_a(i, "R1 R5 pattern");
    for (int i = 0; i < 16; i++) wr_a(i, ~ref_a[i], 1'b1, "R7 no drive");
    for (int i = 15; i >= 0; i--) rd_a(i, "R1 R5 inverse");

    // R6: 8x2 grouping
    wr_b(3, 2'b10, "R6 write");
    rd_b(3, "R6 word at 3");
    rd_b(2, "R6 neighbour");
    rd_b(7, "R6 same column group");
    for (int i = 0; i < 8; i++) wr_b(i, 2'(i + 1), "R6 write");
    for (int i = 0; i < 8; i++) rd_b(i, "R6 R5 words");
    for (int i = 0; i < 8; i++) rd_b(i, "R6 R5 words again");

    @(negedge clk);
    cs_a = 1'b0; cs_b = 1'b0;
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule